// File: doc/BRIEF.md
# Quad SPI Continuous-Read Command Front End

This block is the device side of a serial flash command interface. It oversamples chip select, the serial clock and a 4-bit I/O bus on a fast system clock. It decodes a quad-wide read request, collects a 24-bit address, a mode byte and a configurable number of dummy clocks, and then returns bytes fetched from a byte-wide internal read port, four bits per serial clock.

The mode byte controls a repeat-read state. When the two nibbles of the mode byte are bitwise complements of each other, the block stays in that state after chip select rises. The next transaction then starts directly with the address, with no opcode. Any other mode byte drops the state when the transaction ends. A transaction that shows eight clocks with I/O0 high at its start forces the block back to normal opcode decoding. A transaction cut short before the mode byte is complete also returns the block to normal decoding.

Top module: `qspi_cont_read`

## Requirements
- R1: In normal state the opcode is taken from io_i[0] on 8 serial-clock rising edges, MSB first. Only EBh starts a read. Any other opcode is ignored until cs_n_i rises: io_oe_o stays 0 and cont_mode_o does not change.
- R2: After the opcode, the 24-bit address arrives on 6 rising edges, 4 bits each, most significant nibble first. The mode byte follows on 2 rising edges, high nibble first. Then come dummy_cfg_i rising edges (0 to 15) before any data.
- R3: The read port is used as follows. rd_addr_o is held while rd_en_o pulses for one cycle, and rd_data_i is taken on the next cycle. Each byte is driven on io_o as two nibbles, high nibble first, on successive falling edges. The first nibble goes out on the falling edge after the last mode or dummy rising edge. The address then increments by one per byte and wraps from FFFFFFh to 000000h.
- R4: io_oe_o is 4'hF in the data phase and 4'h0 at every other time, including the opcode, address, mode and dummy phases.
- R5: A mode byte whose high nibble equals the bitwise inverse of its low nibble (for example A5h, 5Ah, C3h) sets cont_mode_o to 1 when cs_n_i next rises.
- R6: While cont_mode_o is 1, a transaction starts with the address on its first rising edge, with no opcode.
- R7: A fully received mode byte whose nibbles are not complementary clears cont_mode_o when cs_n_i rises. The next transaction then needs an opcode.
- R8: cs_n_i rising during the data phase ends the transaction and disables the outputs. The next cs_n_i fall starts a new transaction.
- R9: While cont_mode_o is 1, a transaction whose first 8 rising edges all carry io_i[0]=1 clears cont_mode_o, whatever io_i[3:1] hold. The rest of that transaction is ignored. In normal state the same pattern is the unused opcode FFh.
- R10: If cs_n_i rises before both mode nibbles are taken, cont_mode_o is cleared. If cs_n_i rises during the dummy phase, the captured mode byte decides cont_mode_o as in R5 and R7.
- R11: io_o changes only after a detected serial-clock falling edge in the data phase. It holds each nibble through the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| io_i | input | 4 | Serial data in from host |
| io_o | output | 4 | Serial data out to host |
| io_oe_o | output | 4 | Output enable per I/O line |
| dummy_cfg_i | input | DUMMY_W | Dummy clock count, 0 to 15 |
| rd_addr_o | output | ADDR_W | Read port byte address |
| rd_en_o | output | 1 | Read request, one cycle |
| rd_data_i | input | 8 | Read port data, valid the cycle after rd_en_o |
| cont_mode_o | output | 1 | Repeat-read state active |

## Verification
Every pin passes through two synchronizer flops and an edge detector. A data nibble therefore appears on io_o three to four system cycles after a serial-clock fall, and the bench holds each clock half for six cycles. The bench samples io_o and io_oe_o at the last cycle of the low half, just before it raises the clock, and samples io_o again at the end of the high half to confirm the nibble was held. cont_mode_o settles within four cycles of cs_n_i rising, so the bench reads it after three half periods of chip select high. Expected bytes come from a bench-side address function applied to the start address plus the byte index.

// File: rtl/qspi_ct_pkg.sv
package qspi_ct_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 8;
  localparam int OP_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } ct_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // complementary nibbles keep the repeat-read state
  function automatic logic mode_keeps(logic [NIB_W-1:0] hi, logic [NIB_W-1:0] lo);
    return hi == ~lo;
  endfunction
endpackage

// File: rtl/qspi_ct_sync.sv
module qspi_ct_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qspi_ct_fsm.sv
module qspi_ct_fsm
  import qspi_ct_pkg::*;
#(
  parameter int         ADDR_NIBS = 6,
  parameter int         DUMMY_W   = 4,
  parameter int         CNT_W     = 4,
  parameter logic [7:0] READ_OP   = 8'hEB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic [NIB_W-1:0]   io_i,
  input  logic [DUMMY_W-1:0] dummy_i,
  output logic               addr_shift_o,
  output logic               start_o,
  output logic               fall_o,
  output logic               in_data_o,
  output logic               mbr_o,
  output logic               cont_o
);
  ct_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OP_BITS-2:0] op_q;
  logic [NIB_W-1:0] mode_hi_q;
  logic             sck_q, ones_q, from_cont_q, mode_done_q, mode_cmp_q, cont_q;

  logic             act, rise, fall, cmd_last, addr_last, mode_last, dum_last, no_dummy;
  logic             mbr_hit, mode_end, dum_end;
  logic [OP_BITS-1:0] opcode_full;

  localparam logic [DUMMY_W-1:0] DUM_ONE = DUMMY_W'(1);

  always_comb begin
    act         = ~cs_n_i;
    rise        = sck_i & ~sck_q;
    fall        = ~sck_i & sck_q;
    opcode_full = {op_q, io_i[0]};
    cmd_last    = cnt_q == CNT_W'(OP_BITS - 1);
    addr_last   = cnt_q == CNT_W'(ADDR_NIBS - 1);
    mode_last   = cnt_q == CNT_W'(1);
    dum_last    = cnt_q == CNT_W'(dummy_i - DUM_ONE);
    no_dummy    = dummy_i == '0;
    // eight ones on io[0] at the start of a repeat-read transaction
    mbr_hit     = act & rise & (state_q == ST_MODE) & mode_last & from_cont_q & ones_q & io_i[0];
    mode_end    = act & rise & (state_q == ST_MODE) & mode_last & ~mbr_hit;
    dum_end     = act & rise & (state_q == ST_DUMMY) & dum_last;
  end

  assign addr_shift_o = act & rise & (state_q == ST_ADDR);
  assign start_o      = (mode_end & no_dummy) | dum_end;
  assign fall_o       = act & fall & (state_q == ST_DATA);
  assign in_data_o    = state_q == ST_DATA;
  assign mbr_o        = mbr_hit;
  assign cont_o       = cont_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      op_q        <= '0;
      mode_hi_q   <= '0;
      sck_q       <= 1'b0;
      ones_q      <= 1'b0;
      from_cont_q <= 1'b0;
      mode_done_q <= 1'b0;
      mode_cmp_q  <= 1'b0;
      cont_q      <= 1'b0;
    end else begin
      sck_q <= sck_i;
      if (cs_n_i) begin
        if (state_q != ST_IDLE) begin
          state_q <= ST_IDLE;
          // abort before mode complete leaves mode_done_q low: state cleared
          if (state_q != ST_SKIP) cont_q <= mode_done_q & mode_cmp_q;
        end
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            cnt_q       <= '0;
            ones_q      <= 1'b1;
            mode_done_q <= 1'b0;
            mode_cmp_q  <= 1'b0;
            from_cont_q <= cont_q;
            state_q     <= cont_q ? ST_ADDR : ST_CMD;
          end
          ST_CMD: if (rise) begin
            op_q   <= opcode_full[OP_BITS-2:0];
            ones_q <= ones_q & io_i[0];
            if (cmd_last) begin
              cnt_q   <= '0;
              state_q <= (opcode_full == READ_OP) ? ST_ADDR : ST_SKIP;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_ADDR: if (rise) begin
            ones_q <= ones_q & io_i[0];
            if (addr_last) begin
              cnt_q   <= '0;
              state_q <= ST_MODE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_MODE: if (rise) begin
            if (!mode_last) begin
              mode_hi_q <= io_i;
              ones_q    <= ones_q & io_i[0];
              cnt_q     <= cnt_q + CNT_W'(1);
            end else if (mbr_hit) begin
              cont_q  <= 1'b0;
              state_q <= ST_SKIP;
            end else begin
              mode_done_q <= 1'b1;
              mode_cmp_q  <= mode_keeps(mode_hi_q, io_i);
              cnt_q       <= '0;
              state_q     <= no_dummy ? ST_DATA : ST_DUMMY;
            end
          end
          ST_DUMMY: if (rise) begin
            if (dum_last) begin
              cnt_q   <= '0;
              state_q <= ST_DATA;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_DATA, ST_SKIP: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/qspi_ct_dp.sv
module qspi_ct_dp
  import qspi_ct_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  io_i,
  input  logic              addr_shift_i,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic              in_data_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_en_o,
  output logic [NIB_W-1:0]  io_o,
  output logic [NIB_W-1:0]  io_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] byte_q;
  logic [NIB_W-1:0]  io_q;
  logic              half_q, rd_req_q, rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      byte_q    <= '0;
      io_q      <= '0;
      half_q    <= 1'b0;
      rd_req_q  <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_req_q  <= start_i | (fall_i & half_q);
      rd_pend_q <= rd_req_q;
      if (rd_pend_q) byte_q <= rd_data_i;
      if (addr_shift_i) begin
        addr_q <= {addr_q[ADDR_W-NIB_W-1:0], io_i};
      end else if (start_i) begin
        half_q <= 1'b0;
      end else if (fall_i) begin
        if (!half_q) begin
          io_q   <= byte_q[BYTE_W-1:NIB_W];
          half_q <= 1'b1;
        end else begin
          io_q   <= byte_q[NIB_W-1:0];
          half_q <= 1'b0;
          addr_q <= addr_q + ADDR_W'(1);
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign rd_en_o   = rd_req_q;
  assign io_o      = io_q;
  assign io_oe_o   = {NIB_W{in_data_i}};
endmodule

// File: rtl/qspi_cont_read.sv
module qspi_cont_read
  import qspi_ct_pkg::*;
#(
  parameter int         ADDR_W      = 24,
  parameter int         DUMMY_W     = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] READ_OP     = 8'hEB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic [3:0]         io_i,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  input  logic [DUMMY_W-1:0] dummy_cfg_i,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               rd_en_o,
  input  logic [7:0]         rd_data_i,
  output logic               cont_mode_o
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int CNT_W     = imax(imax($clog2(OP_BITS), $clog2(ADDR_NIBS)), DUMMY_W);

  logic             cs_n_s, sck_s;
  logic [NIB_W-1:0] io_s;
  logic             fsm_shift, fsm_start, fsm_fall, fsm_data, fsm_mbr;

  qspi_ct_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b1)) i_sync_cs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cs_n_i),
    .q_o   (cs_n_s)
  );

  qspi_ct_sync #(.W(NIB_W + 1), .STAGES(SYNC_STAGES), .RST('0)) i_sync_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, io_i}),
    .q_o   ({sck_s, io_s})
  );

  qspi_ct_fsm #(
    .ADDR_NIBS(ADDR_NIBS),
    .DUMMY_W  (DUMMY_W),
    .CNT_W    (CNT_W),
    .READ_OP  (READ_OP)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_n_s),
    .sck_i       (sck_s),
    .io_i        (io_s),
    .dummy_i     (dummy_cfg_i),
    .addr_shift_o(fsm_shift),
    .start_o     (fsm_start),
    .fall_o      (fsm_fall),
    .in_data_o   (fsm_data),
    .mbr_o       (fsm_mbr),
    .cont_o      (cont_mode_o)
  );

  qspi_ct_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_i        (io_s),
    .addr_shift_i(fsm_shift),
    .start_i     (fsm_start),
    .fall_i      (fsm_fall),
    .in_data_i   (fsm_data),
    .rd_data_i   (rd_data_i),
    .rd_addr_o   (rd_addr_o),
    .rd_en_o     (rd_en_o),
    .io_o        (io_o),
    .io_oe_o     (io_oe_o)
  );
endmodule

// File: rtl/qspi_ct_chk.sv
module qspi_ct_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s_i,
  input logic              fall_i,
  input logic              mbr_i,
  input logic              cont_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [3:0]        dout_i,
  input logic [3:0]        oe_i
);
  // R4
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i != 4'h0) |-> !$past(cs_s_i));

  // R3
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> !rd_en_i);

  // R3
  rd_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> $stable(rd_addr_i));

  // R11
  dout_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_i) |-> $past(fall_i));

  // R5
  cont_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cont_i) |-> $past(cs_s_i));

  // R7
  cont_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cont_i) |-> ($past(cs_s_i) || $past(mbr_i)));

  // R9
  mbr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbr_i |=> !cont_i);
endmodule

bind qspi_cont_read qspi_ct_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s_i   (cs_n_s),
  .fall_i   (fsm_fall),
  .mbr_i    (fsm_mbr),
  .cont_i   (cont_mode_o),
  .rd_en_i  (rd_en_o),
  .rd_addr_i(rd_addr_o),
  .dout_i   (io_o),
  .oe_i     (io_oe_o)
);

// File: tb/test_qspi_cont_read.sv
module test_qspi_cont_read;
  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic [3:0]  io_drv = 4'h0;
  logic [3:0]  dummy_cfg = 4'd4;
  logic [7:0]  rd_data = 8'h00;
  logic [3:0]  io_o, io_oe;
  logic [23:0] rd_addr;
  logic        rd_en, cont;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  qspi_cont_read i_qspi_cont_read (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cs_n_i     (cs_n),
    .sck_i      (sck),
    .io_i       (io_drv),
    .io_o       (io_o),
    .io_oe_o    (io_oe),
    .dummy_cfg_i(dummy_cfg),
    .rd_addr_o  (rd_addr),
    .rd_en_o    (rd_en),
    .rd_data_i  (rd_data),
    .cont_mode_o(cont)
  );

  function automatic logic [7:0] mem_f(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hC3;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem_f(rd_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sck_cyc(input logic [3:0] nib, output logic [3:0] rd, output logic [3:0] oe,
                         output logic [3:0] rd_hi);
    io_drv = nib;
    repeat (HP) @(negedge clk);
    rd = io_o;
    oe = io_oe;
    sck = 1'b1;
    repeat (HP) @(negedge clk);
    rd_hi = io_o;
    sck = 1'b0;
  endtask

  task automatic xfer(input bit send_op, input logic [7:0] op, input logic [23:0] addr,
                      input logic [7:0] mode, input int n_mode, input int n_dum, input int nb,
                      output logic [31:0] got, output bit pre_oe, output bit dat_all,
                      output bit dat_any, output bit hold_ok);
    logic [3:0] r, o, h, r2, o2, h2;
    got = '0; pre_oe = 0; dat_all = 1; dat_any = 0; hold_ok = 1;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    if (send_op) for (int i = 7; i >= 0; i--) begin
      sck_cyc({3'b000, op[i]}, r, o, h);
      pre_oe |= (o != 4'h0);
    end
    for (int i = 5; i >= 0; i--) begin
      sck_cyc(addr[4*i +: 4], r, o, h);
      pre_oe |= (o != 4'h0);
    end
    for (int i = 0; i < n_mode; i++) begin
      sck_cyc((i == 0) ? mode[7:4] : mode[3:0], r, o, h);
      pre_oe |= (o != 4'h0);
    end
    for (int i = 0; i < n_dum; i++) begin
      sck_cyc(4'h0, r, o, h);
      pre_oe |= (o != 4'h0);
    end
    for (int b = 0; b < nb; b++) begin
      sck_cyc(4'h0, r, o, h);
      sck_cyc(4'h0, r2, o2, h2);
      got[8*b +: 8] = {r, r2};
      if (o != 4'hF || o2 != 4'hF) dat_all = 0;
      if (o != 4'h0 || o2 != 4'h0) dat_any = 1;
      if (h != r || h2 != r2) hold_ok = 0;
    end
    cs_n = 1'b1;
    io_drv = 4'h0;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic mbr_seq();
    logic [3:0] r, o, h;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < 8; i++) sck_cyc({3'(i), 1'b1}, r, o, h);
    for (int i = 0; i < 4; i++) sck_cyc(4'h0, r, o, h);
    cs_n = 1'b1;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input logic [23:0] addr, input int nb,
                             input logic [31:0] got);
    for (int b = 0; b < nb; b++) begin
      logic [23:0] a;
      a = addr + 24'(b);
      check(got[8*b +: 8] == mem_f(a), req, 32'(got[8*b +: 8]), 32'(mem_f(a)));
    end
  endtask

  task automatic t_reset();
    check(io_oe == 4'h0, "R4 reset oe", 32'(io_oe), 0);
    check(cont == 1'b0, "R5 reset cont", 32'(cont), 0);
    check(rd_en == 1'b0, "R3 reset rd_en", 32'(rd_en), 0);
  endtask

  task automatic t_normal();
    logic [31:0] got; bit pre, all, any, hold;
    dummy_cfg = 4'd4;
    xfer(1, 8'hEB, 24'h123456, 8'h00, 2, 4, 3, got, pre, all, any, hold);
    check_bytes("R3 normal read bytes", 24'h123456, 3, got);
    check(!pre, "R4 oe before data", 32'(pre), 0);
    check(all, "R4 oe in data", 32'(all), 1);
    check(hold, "R11 nibble hold", 32'(hold), 1);
    check(io_oe == 4'h0, "R8 oe after cs high", 32'(io_oe), 0);
    check(!cont, "R7 non-complementary stays normal", 32'(cont), 0);
  endtask

  task automatic t_enter();
    logic [31:0] got; bit pre, all, any, hold;
    xfer(1, 8'hEB, 24'h000100, 8'hA5, 2, 4, 2, got, pre, all, any, hold);
    check_bytes("R2 read bytes A5", 24'h000100, 2, got);
    check(cont, "R5 enter with A5", 32'(cont), 1);
  endtask

  task automatic t_repeat();
    logic [31:0] got; bit pre, all, any, hold;
    xfer(0, 8'h00, 24'hFFFFFF, 8'h5A, 2, 4, 2, got, pre, all, any, hold);
    check_bytes("R6 repeat read no opcode (R3 wrap)", 24'hFFFFFF, 2, got);
    check(cont, "R6 stays with 5A", 32'(cont), 1);
  endtask

  task automatic t_exit();
    logic [31:0] got; bit pre, all, any, hold;
    xfer(0, 8'h00, 24'h00ABCD, 8'h33, 2, 4, 1, got, pre, all, any, hold);
    check_bytes("R6 last repeat read", 24'h00ABCD, 1, got);
    check(!cont, "R7 exit with 33", 32'(cont), 0);
    xfer(1, 8'hEB, 24'h00ABCD, 8'h00, 2, 4, 1, got, pre, all, any, hold);
    check_bytes("R7 opcode decoded again", 24'h00ABCD, 1, got);
  endtask

  task automatic t_bad_op();
    logic [31:0] got; bit pre, all, any, hold;
    xfer(1, 8'h03, 24'h0000A5, 8'hA5, 2, 4, 2, got, pre, all, any, hold);
    check(!pre && !any, "R1 unknown opcode ignored", {30'b0, pre, any}, 0);
    check(!cont, "R1 cont unchanged", 32'(cont), 0);
  endtask

  task automatic t_mbr();
    logic [31:0] got; bit pre, all, any, hold;
    xfer(1, 8'hEB, 24'h345678, 8'h96, 2, 4, 1, got, pre, all, any, hold);
    check(cont, "R9 precondition 96", 32'(cont), 1);
    mbr_seq();
    check(!cont, "R9 reset sequence clears", 32'(cont), 0);
    xfer(1, 8'hEB, 24'h345678, 8'h00, 2, 4, 1, got, pre, all, any, hold);
    check_bytes("R9 normal read after reset sequence", 24'h345678, 1, got);
    mbr_seq();
    check(!cont, "R9 FFh in normal state", 32'(cont), 0);
  endtask

  task automatic t_abort();
    logic [31:0] got; bit pre, all, any, hold;
    dummy_cfg = 4'd6;
    xfer(1, 8'hEB, 24'h0A0B0C, 8'hC3, 2, 2, 0, got, pre, all, any, hold);
    check(!pre, "R10 no oe on dummy abort", 32'(pre), 0);
    check(cont, "R10 dummy abort commits C3", 32'(cont), 1);
    xfer(0, 8'h00, 24'h0A0B0C, 8'h5A, 1, 0, 0, got, pre, all, any, hold);
    check(!cont, "R10 mode abort clears", 32'(cont), 0);
    xfer(1, 8'hEB, 24'h0A0B0C, 8'h00, 2, 6, 1, got, pre, all, any, hold);
    check_bytes("R10 read after mode abort", 24'h0A0B0C, 1, got);
  endtask

  task automatic t_dummy0();
    logic [31:0] got; bit pre, all, any, hold;
    dummy_cfg = 4'd0;
    xfer(1, 8'hEB, 24'h0F0F0F, 8'h00, 2, 0, 2, got, pre, all, any, hold);
    check_bytes("R2 zero dummy read", 24'h0F0F0F, 2, got);
    check(all, "R4 oe zero dummy", 32'(all), 1);
    dummy_cfg = 4'd4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_normal();
    t_enter();
    t_repeat();
    t_exit();
    t_bad_op();
    t_mbr();
    t_abort();
    t_dummy0();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule